// File: doc/BRIEF.md
# Forward-Link Serial Encoding Chain

This block turns an uncoded NRZ-L serial bit stream into a channel symbol stream. Each input bit arrives on `bit_in` with a one-cycle `bit_vld` strobe. The bit then passes through three stages in a fixed sequence. The first is a self-synchronizing scrambler with taps at delays 3 and 5. The second is an NRZ-L to NRZ-M differential encoder. The third is a rate 1/2, constraint-length-7 convolutional encoder with generators 171 and 133 (octal). Symbols leave on `sym_out`, and `sym_vld` marks each one.

Every stage has its own bypass selection, so the output can take several formats: plain data, scrambled data, differentially coded data, or convolutionally coded symbols, alone or in combination. With the convolutional stage active, each bit produces two symbols on consecutive cycles, so the symbol rate is twice the bit rate. With that stage bypassed, one symbol leaves for each bit. The three mode inputs are captured only while the synchronous reset is held. A mode change therefore takes effect at the next reset.

Top module: `fwdenc_chain`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `sym_vld` and `sym_out` are 0. All shift registers start from zero, so the first outputs after reset treat every earlier bit as 0.
- R2: With the scrambler selected, the scrambled bit is y[n] = x[n] XOR y[n-3] XOR y[n-5]. Here y holds earlier scrambled outputs, and any y from before reset counts as 0.
- R3: With the scrambler bypassed, its stage passes each input bit through unchanged.
- R4: With differential coding selected, the stage output is z[n] = y[n] XOR z[n-1], with z before the first bit equal to 0.
- R5: With differential coding bypassed, z[n] = y[n].
- R6: With the convolutional stage selected, each bit u[n] produces two symbols on two consecutive cycles. The first is u[n]^u[n-1]^u[n-2]^u[n-3]^u[n-6] (generator 171 octal). The second is u[n]^u[n-2]^u[n-3]^u[n-5]^u[n-6] (generator 133 octal). In this mode `bit_vld` must not be high in two adjacent cycles.
- R7: With the convolutional stage bypassed, each bit yields exactly one symbol equal to u[n], and bits may arrive on every cycle.
- R8: The stage order is fixed: scrambler, then differential encoder, then convolutional encoder.
- R9: The first symbol of a bit is valid 3 clock edges after the edge that samples `bit_vld`.
- R10: The mode inputs are captured on clock edges where `rst` is high. Changing them while `rst` is low does not alter the output.
- R11: After reset, the number of `sym_vld` strobes is exactly twice the number of input bits with the convolutional stage selected, and equal to it otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; mode inputs are captured while it is high |
| mode_scramble | input | 1 | 1 selects the scrambler, 0 bypasses it |
| mode_diff | input | 1 | 1 selects NRZ-M differential coding, 0 bypasses it |
| mode_conv | input | 1 | 1 selects the rate 1/2 convolutional encoder, 0 bypasses it |
| bit_in | input | 1 | Serial NRZ-L data bit |
| bit_vld | input | 1 | One-cycle strobe marking a valid `bit_in` |
| sym_out | output | 1 | Serial output symbol |
| sym_vld | output | 1 | One-cycle strobe marking a valid `sym_out` |

## Verification
The assertions take for granted that, with the convolutional stage selected, `bit_vld` is never high in two adjacent cycles, since the second symbol of a pair needs the following cycle. They also assume that reset is held from time zero. The stimulus spaces bits two cycles apart whenever the convolutional stage is selected. With that stage bypassed, it mixes back-to-back bits with gaps. Every run starts with a reset of several cycles, and the mode inputs are inverted right after reset is released, so that the captured mode stays the only one in force.

// File: rtl/fwdenc_pkg.sv
package fwdenc_pkg;
   typedef struct packed {
      logic scr_on;
      logic diff_on;
      logic conv_on;
   } fwdenc_mode_t;

   function automatic logic parity_mask(input logic [31:0] word, input logic [31:0] mask);
      return ^(word & mask);
   endfunction
endpackage

// File: rtl/fwdenc_scrambler.sv
module fwdenc_scrambler #(
   parameter int TAP_NEAR = 3,
   parameter int TAP_FAR  = 5
) (
   input  logic clk,
   input  logic rst,
   input  logic stage_on,
   input  logic din,
   input  logic vin,
   output logic dout,
   output logic vout
);
   localparam int HW = TAP_FAR;

   generate
      if (TAP_NEAR < 1 || TAP_FAR <= TAP_NEAR) begin : g_bad_taps
         $error("fwdenc_scrambler: taps must satisfy 1 <= TAP_NEAR < TAP_FAR");
      end
   endgenerate

   logic [HW-1:0] hist;   // hist[0] is the newest scrambled bit
   logic          mixed;

   assign mixed = din ^ hist[TAP_NEAR-1] ^ hist[TAP_FAR-1];

   always_ff @(posedge clk) begin
      if (rst) begin
         hist <= '0;
         dout <= 1'b0;
         vout <= 1'b0;
      end else begin
         vout <= vin;
         if (vin) begin
            if (stage_on) begin
               dout <= mixed;
               hist <= {hist[HW-2:0], mixed};
            end else begin
               dout <= din;
            end
         end
      end
   end

   AST_SCR_BYPASS: assert property (@(posedge clk) disable iff (rst)
      (vout && !stage_on) |-> (dout == $past(din)));   // R3
endmodule

// File: rtl/fwdenc_nrzm.sv
module fwdenc_nrzm (
   input  logic clk,
   input  logic rst,
   input  logic stage_on,
   input  logic din,
   input  logic vin,
   output logic dout,
   output logic vout
);
   logic level;

   always_ff @(posedge clk) begin
      if (rst) begin
         level <= 1'b0;
         dout  <= 1'b0;
         vout  <= 1'b0;
      end else begin
         vout <= vin;
         if (vin) begin
            if (stage_on) begin
               level <= din ^ level;
               dout  <= din ^ level;
            end else begin
               dout <= din;
            end
         end
      end
   end

   AST_NRZM_BYPASS: assert property (@(posedge clk) disable iff (rst)
      (vout && !stage_on) |-> (dout == $past(din)));   // R5
endmodule

// File: rtl/fwdenc_conv.sv
module fwdenc_conv
   import fwdenc_pkg::*;
#(
   parameter int          K     = 7,
   parameter logic [K-1:0] GEN_A = 7'o171,
   parameter logic [K-1:0] GEN_B = 7'o133
) (
   input  logic clk,
   input  logic rst,
   input  logic stage_on,
   input  logic din,
   input  logic vin,
   output logic sym,
   output logic sym_vld
);
   localparam int MW = K - 1;

   generate
      if (K < 3 || K > 16) begin : g_bad_k
         $error("fwdenc_conv: constraint length out of supported range");
      end
      if (!GEN_A[K-1] || !GEN_B[K-1]) begin : g_bad_gen
         $error("fwdenc_conv: generators must tap the current bit");
      end
   endgenerate

   logic [MW-1:0] mem;    // mem[MW-1] is the newest past bit
   logic [K-1:0]  window;
   logic          pend, pend_sym;

   assign window = {din, mem};

   always_ff @(posedge clk) begin
      if (rst) begin
         mem      <= '0;
         pend     <= 1'b0;
         pend_sym <= 1'b0;
         sym      <= 1'b0;
         sym_vld  <= 1'b0;
      end else if (vin) begin
         sym_vld <= 1'b1;
         if (stage_on) begin
            sym      <= parity_mask(32'(window), 32'(GEN_A));
            pend_sym <= parity_mask(32'(window), 32'(GEN_B));
            pend     <= 1'b1;
            mem      <= {din, mem[MW-1:1]};
         end else begin
            sym  <= din;
            pend <= 1'b0;
         end
      end else if (pend) begin
         sym     <= pend_sym;
         sym_vld <= 1'b1;
         pend    <= 1'b0;
      end else begin
         sym_vld <= 1'b0;
      end
   end

   AST_PAIR_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
      (vin && stage_on) |=> sym_vld ##1 sym_vld);   // R6
   AST_ONE_PER_BIT: assert property (@(posedge clk) disable iff (rst)
      (sym_vld && !stage_on) |-> $past(vin));   // R7
endmodule

// File: rtl/fwdenc_chain.sv
module fwdenc_chain
   import fwdenc_pkg::*;
#(
   parameter int SCR_NEAR = 3,
   parameter int SCR_FAR  = 5,
   parameter int CONV_K   = 7,
   parameter logic [CONV_K-1:0] CONV_GA = 7'o171,
   parameter logic [CONV_K-1:0] CONV_GB = 7'o133
) (
   input  logic clk,
   input  logic rst,
   input  logic mode_scramble,
   input  logic mode_diff,
   input  logic mode_conv,
   input  logic bit_in,
   input  logic bit_vld,
   output logic sym_out,
   output logic sym_vld
);
   fwdenc_mode_t mode;
   logic s1_d, s1_v, s2_d, s2_v;

   always_ff @(posedge clk) begin
      if (rst) begin
         mode.scr_on  <= mode_scramble;
         mode.diff_on <= mode_diff;
         mode.conv_on <= mode_conv;
      end
   end

   fwdenc_scrambler #(.TAP_NEAR(SCR_NEAR), .TAP_FAR(SCR_FAR)) u_scr (
      .clk(clk), .rst(rst), .stage_on(mode.scr_on),
      .din(bit_in), .vin(bit_vld), .dout(s1_d), .vout(s1_v));

   fwdenc_nrzm u_diff (
      .clk(clk), .rst(rst), .stage_on(mode.diff_on),
      .din(s1_d), .vin(s1_v), .dout(s2_d), .vout(s2_v));

   fwdenc_conv #(.K(CONV_K), .GEN_A(CONV_GA), .GEN_B(CONV_GB)) u_conv (
      .clk(clk), .rst(rst), .stage_on(mode.conv_on),
      .din(s2_d), .vin(s2_v), .sym(sym_out), .sym_vld(sym_vld));

   AST_BIT_SPACING: assert property (@(posedge clk) disable iff (rst)
      (bit_vld && mode.conv_on) |=> !bit_vld);   // R6
   AST_RESET_QUIET: assert property (@(posedge clk)
      rst |=> (!sym_vld && !sym_out));   // R1
   AST_LATENCY: assert property (@(posedge clk) disable iff (rst)
      (s2_v) |=> sym_vld);   // R9
endmodule

// File: tb/fwdenc_chain_test.sv
module fwdenc_chain_test;
   localparam int CLK_PERIOD = 10;
   localparam int NBITS = 48;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic mode_scramble = 1'b0, mode_diff = 1'b0, mode_conv = 1'b0;
   logic bit_in = 1'b0, bit_vld = 1'b0;
   logic sym_out, sym_vld;

   int checks = 0, fails = 0;
   int cyc = 0, ncap = 0, first_in = -1, first_out = -1;
   logic cap [0:255];
   logic expv [0:255];

   always #(CLK_PERIOD/2) clk = ~clk;

   fwdenc_chain uut (
      .clk(clk), .rst(rst), .mode_scramble(mode_scramble), .mode_diff(mode_diff),
      .mode_conv(mode_conv), .bit_in(bit_in), .bit_vld(bit_vld),
      .sym_out(sym_out), .sym_vld(sym_vld));

   always @(negedge clk) begin
      #1;
      if (rst) begin
         ncap = 0; first_in = -1; first_out = -1;
      end else begin
         if (bit_vld && first_in < 0) first_in = cyc;
         if (sym_vld) begin
            if (first_out < 0) first_out = cyc;
            if (ncap < 256) cap[ncap] = sym_out;
            ncap++;
         end
      end
      cyc++;
   end

   task automatic check(input bit ok, input string req, input int act, input int exp_v);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
      end
   endtask

   task automatic run_cfg(input int c);
      logic x [0:NBITS-1];
      logic y [0:NBITS-1];
      logic z [0:NBITS-1];
      logic [7:0] lfsr;
      int nexp;
      bit scr, dif, cnv;
      string tag;
      scr = c[0]; dif = c[1]; cnv = c[2];
      lfsr = 8'(8'hA5 ^ (c * 37 + 1));
      for (int n = 0; n < NBITS; n++) begin
         if (n < 6) x[n] = 1'b0;
         else if (n < 12) x[n] = 1'b1;
         else begin
            x[n] = lfsr[0];
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
         end
      end
      // R8: scrambler, then differential, then convolutional
      for (int n = 0; n < NBITS; n++) begin
         if (scr) y[n] = x[n] ^ ((n >= 3) ? y[n-3] : 1'b0) ^ ((n >= 5) ? y[n-5] : 1'b0);
         else     y[n] = x[n];
         if (dif) z[n] = y[n] ^ ((n >= 1) ? z[n-1] : 1'b0);
         else     z[n] = y[n];
      end
      nexp = 0;
      for (int n = 0; n < NBITS; n++) begin
         if (cnv) begin
            logic a, b;
            a = z[n] ^ ((n>=1)?z[n-1]:1'b0) ^ ((n>=2)?z[n-2]:1'b0) ^ ((n>=3)?z[n-3]:1'b0) ^ ((n>=6)?z[n-6]:1'b0);
            b = z[n] ^ ((n>=2)?z[n-2]:1'b0) ^ ((n>=3)?z[n-3]:1'b0) ^ ((n>=5)?z[n-5]:1'b0) ^ ((n>=6)?z[n-6]:1'b0);
            expv[nexp] = a; expv[nexp+1] = b; nexp += 2;
         end else begin
            expv[nexp] = z[n]; nexp++;
         end
      end
      tag = {scr ? "R2" : "R3", "/", dif ? "R4" : "R5", "/", cnv ? "R6" : "R7", "/R8"};

      @(negedge clk);
      rst = 1'b1; bit_vld = 1'b0; bit_in = 1'b0;
      mode_scramble = scr; mode_diff = dif; mode_conv = cnv;
      repeat (3) @(negedge clk);
      check(sym_vld === 1'b0 && sym_out === 1'b0, "R1 reset outputs", int'({sym_vld, sym_out}), 0);
      rst = 1'b0;
      // R10: inverted mode after reset must not take effect
      mode_scramble = ~scr; mode_diff = ~dif; mode_conv = ~cnv;
      @(negedge clk);
      check(sym_vld === 1'b0, "R1 first cycle after reset", int'(sym_vld), 0);
      for (int n = 0; n < NBITS; n++) begin
         bit_in = x[n]; bit_vld = 1'b1;
         @(negedge clk);
         bit_vld = 1'b0;
         if (cnv) @(negedge clk);
         else if (n % 3 == 0) repeat (2) @(negedge clk);
      end
      repeat (8) @(negedge clk);
      check(ncap == nexp, "R11 symbol count", ncap, nexp);
      check(first_out - first_in == 3, "R9 latency", first_out - first_in, 3);
      for (int i = 0; i < nexp && i < ncap; i++)
         check(cap[i] === expv[i], {tag, " R10 symbol"}, int'(cap[i]), int'(expv[i]));
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (2) @(negedge clk);
      for (int c = 0; c < 8; c++) run_cfg(c);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule